// File: doc/BRIEF.md
# Floating-Point Compare Condition-Code Unit

This block compares two floating-point operands, either both single precision or both double precision, and turns the outcome into a 2-bit condition code. The code goes into one of several condition fields, all held in a register inside the block. On the same clock edge the unit updates its exception flag vector and its trap type output.

Two compare forms are supported. The quiet form tolerates quiet NaNs. The signaling form treats every NaN operand as an invalid operation. The trap mask has the same bit layout as the flag vector. If a raised flag is also enabled in the mask, the unit requests an IEEE exception trap, and in that case the condition register is left untouched.

A request is a single-cycle strobe. Its results appear at the outputs after the next rising clock edge and stay there until the next request.

Top module: `fcmp_cc_unit`

## Requirements
- R1: While reset is asserted and directly after it, every condition field reads 0, the flag vector reads 0 and the trap type reads 0 (no trap).
- R2: One cycle after a request, the field chosen by `field_sel` holds the compare result. The codes are 0 for equal, 1 for first operand less, 2 for first operand greater, and 3 for unordered. Equal takes priority over less, and less takes priority over greater.
- R3: Positive zero and negative zero compare equal, whatever their signs and whichever operand holds them.
- R4: If either operand is a NaN (all-ones exponent, non-zero fraction), the result is unordered (3).
- R5: In the quiet form (`signaling`=0), the invalid flag (flag bit 4) is set only if an operand is a signaling NaN, which is a NaN whose fraction MSB is 0. Flag bits 3..0 are always 0.
- R6: In the signaling form (`signaling`=1), the invalid flag is set for any NaN operand, quiet or signaling.
- R7: When the invalid flag is raised and `trap_mask` bit 4 is set, `trap_type` becomes 1 (IEEE exception) and no condition field changes. Mask bits 3..0 never cause a trap. Otherwise `trap_type` is 0.
- R8: A request changes at most the selected field. Cycles without a request leave every field unchanged.
- R9: With `is_double`=0, the operands are read from bits 31..0 only, and bits 63..32 have no effect. With `is_double`=1, all 64 bits form the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Compare request strobe |
| op_a | input | 64 | First operand (single precision in bits 31..0) |
| op_b | input | 64 | Second operand (single precision in bits 31..0) |
| is_double | input | 1 | 1 = double precision, 0 = single precision |
| signaling | input | 1 | 1 = signaling compare, 0 = quiet compare |
| trap_mask | input | 5 | Trap enables; bit 4 enables invalid |
| field_sel | input | SEL_W (2) | Index of the destination condition field |
| cond_fields | output | 2*NUM_FIELDS (8) | Condition register; field i at bits 2i+1..2i |
| exc_flags | output | 5 | Flags of the last request; bit 4 = invalid |
| trap_type | output | 2 | 0 = none, 1 = IEEE exception |

## Verification
The assertions assume that `req`, the operands and the selects are stable across each rising edge. They also assume that no request is expected to leave the other fields unchanged unless it targets a valid index. With the default of four fields, every 2-bit index is valid. The NaN property classifies operands only in double precision, so it relies on the bench issuing double requests with an untrapped NaN. The bench does this in its sweep. The bench drives every input on the falling edge and holds it for a full cycle. It rotates `field_sel` through all indices, and it sweeps every pair from a class table (zeros, subnormals, normals, infinities, both NaN kinds) in both precisions, in both forms, and under both mask settings.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
   localparam int SP_EXP_W  = 8;
   localparam int SP_FRAC_W = 23;
   localparam int DP_EXP_W  = 11;
   localparam int DP_FRAC_W = 52;
   localparam int SP_W      = 1 + SP_EXP_W + SP_FRAC_W;
   localparam int DP_W      = 1 + DP_EXP_W + DP_FRAC_W;
   localparam int MAG_W     = DP_W - 1;

   localparam int FLAG_W    = 5;
   localparam int FLAG_INV  = 4;

   typedef enum logic [1:0] {
      CC_EQ = 2'd0,
      CC_LT = 2'd1,
      CC_GT = 2'd2,
      CC_UN = 2'd3
   } cc_e;

   typedef enum logic [1:0] {
      TRAP_NONE = 2'd0,
      TRAP_IEEE = 2'd1
   } trap_e;

   typedef struct packed {
      logic             nan;
      logic             snan;
      logic             zero;
      logic             sign;
      logic [MAG_W-1:0] mag;
   } fp_class_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
   import fcmp_pkg::*;
(
   input  logic [DP_W-1:0] raw,
   input  logic            is_dbl,
   output fp_class_t       cls
);
   logic                 s_sign, d_sign;
   logic                 s_exp_ones, d_exp_ones;
   logic                 s_frac_nz, d_frac_nz;
   logic                 s_quiet, d_quiet;
   logic [MAG_W-1:0]     s_mag, d_mag;

   always_comb begin
      s_sign     = raw[SP_W-1];
      s_exp_ones = &raw[SP_W-2 -: SP_EXP_W];
      s_frac_nz  = |raw[SP_FRAC_W-1:0];
      s_quiet    = raw[SP_FRAC_W-1];
      s_mag      = MAG_W'(raw[SP_W-2:0]);

      d_sign     = raw[DP_W-1];
      d_exp_ones = &raw[DP_W-2 -: DP_EXP_W];
      d_frac_nz  = |raw[DP_FRAC_W-1:0];
      d_quiet    = raw[DP_FRAC_W-1];
      d_mag      = raw[DP_W-2:0];

      if (is_dbl) begin
         cls.sign = d_sign;
         cls.nan  = d_exp_ones & d_frac_nz;
         cls.snan = d_exp_ones & d_frac_nz & ~d_quiet;
         cls.mag  = d_mag;
      end else begin
         cls.sign = s_sign;
         cls.nan  = s_exp_ones & s_frac_nz;
         cls.snan = s_exp_ones & s_frac_nz & ~s_quiet;
         cls.mag  = s_mag;
      end
      cls.zero = (cls.mag == '0);
   end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
   import fcmp_pkg::*;
(
   input  fp_class_t cls_a,
   input  fp_class_t cls_b,
   output cc_e       cc,
   output logic      any_nan,
   output logic      any_snan
);
   function automatic logic less_than(input fp_class_t x, input fp_class_t y);
      if (x.zero && y.zero)       return 1'b0;
      else if (x.sign != y.sign)  return x.sign;
      else if (!x.sign)           return x.mag < y.mag;
      else                        return x.mag > y.mag;
   endfunction

   logic eq, lt, gt;

   always_comb begin
      any_nan  = cls_a.nan  | cls_b.nan;
      any_snan = cls_a.snan | cls_b.snan;
      eq = (cls_a.zero && cls_b.zero) ||
           ((cls_a.sign == cls_b.sign) && (cls_a.mag == cls_b.mag));
      lt = less_than(cls_a, cls_b);
      gt = less_than(cls_b, cls_a) && !eq;
      if (any_nan)   cc = CC_UN;
      else if (eq)   cc = CC_EQ;
      else if (lt)   cc = CC_LT;
      else if (gt)   cc = CC_GT;
      else           cc = CC_UN;
   end
endmodule

// File: rtl/fcmp_field_reg.sv
module fcmp_field_reg
   import fcmp_pkg::*;
#(
   parameter int NUM_FIELDS = 4,
   localparam int SEL_W = $clog2(NUM_FIELDS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [SEL_W-1:0]        wr_sel,
   input  cc_e                     wr_cc,
   output logic [2*NUM_FIELDS-1:0] fields
);
   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
      logic [1:0] slot;
      always_ff @(posedge clk) begin
         if (!rst_n)
            slot <= CC_EQ;
         else if (wr_en && (wr_sel == SEL_W'(i)))
            slot <= wr_cc;
      end
      assign fields[2*i +: 2] = slot;
   end
endmodule

// File: rtl/fcmp_cc_unit.sv
module fcmp_cc_unit
   import fcmp_pkg::*;
#(
   parameter int NUM_FIELDS = 4,
   localparam int SEL_W = $clog2(NUM_FIELDS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req,
   input  logic [63:0]             op_a,
   input  logic [63:0]             op_b,
   input  logic                    is_double,
   input  logic                    signaling,
   input  logic [4:0]              trap_mask,
   input  logic [SEL_W-1:0]        field_sel,
   output logic [2*NUM_FIELDS-1:0] cond_fields,
   output logic [4:0]              exc_flags,
   output logic [1:0]              trap_type
);
   if (NUM_FIELDS < 2 || NUM_FIELDS > 16) begin : g_bad_fields
      $error("fcmp_cc_unit: NUM_FIELDS must lie in 2..16");
   end
   if (DP_W != 64 || FLAG_W != 5) begin : g_bad_format
      $error("fcmp_cc_unit: operand or flag width mismatch");
   end

   logic [63:0] ops [2];
   fp_class_t   cls [2];

   assign ops[0] = op_a;
   assign ops[1] = op_b;

   for (genvar k = 0; k < 2; k++) begin : g_cls
      fcmp_classify u_cls (
         .raw    (ops[k]),
         .is_dbl (is_double),
         .cls    (cls[k])
      );
   end

   cc_e  cc;
   logic any_nan, any_snan;

   fcmp_order u_order (
      .cls_a    (cls[0]),
      .cls_b    (cls[1]),
      .cc       (cc),
      .any_nan  (any_nan),
      .any_snan (any_snan)
   );

   logic [FLAG_W-1:0] flags_d;
   logic              trap_d;

   always_comb begin
      flags_d           = '0;
      flags_d[FLAG_INV] = signaling ? any_nan : any_snan;
      trap_d            = |(flags_d & trap_mask);
   end

   fcmp_field_reg #(.NUM_FIELDS(NUM_FIELDS)) u_fields (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (req && !trap_d),
      .wr_sel (field_sel),
      .wr_cc  (cc),
      .fields (cond_fields)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exc_flags <= '0;
         trap_type <= TRAP_NONE;
      end else if (req) begin
         exc_flags <= flags_d;
         trap_type <= trap_d ? TRAP_IEEE : TRAP_NONE;
      end
   end
endmodule

// File: rtl/fcmp_cc_checker.sv
module fcmp_cc_checker
   import fcmp_pkg::*;
#(
   parameter int NUM_FIELDS = 4,
   localparam int SEL_W = $clog2(NUM_FIELDS)
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    req,
   input logic [63:0]             op_a,
   input logic [63:0]             op_b,
   input logic                    is_double,
   input logic [4:0]              trap_mask,
   input logic [SEL_W-1:0]        field_sel,
   input logic [2*NUM_FIELDS-1:0] cond_fields,
   input logic [4:0]              exc_flags,
   input logic [1:0]              trap_type
);
   logic [2*NUM_FIELDS-1:0] prev_fields;
   logic [SEL_W-1:0]        sel_q;
   logic [NUM_FIELDS-1:0]   changed;

   always_ff @(posedge clk) begin
      prev_fields <= cond_fields;
      sel_q       <= field_sel;
   end

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_chg
      assign changed[i] = cond_fields[2*i +: 2] != prev_fields[2*i +: 2];
   end

   logic dbl_nan_a, dbl_nan_b;
   assign dbl_nan_a = (&op_a[62:52]) && (|op_a[51:0]);
   assign dbl_nan_b = (&op_b[62:52]) && (|op_b[51:0]);

   // R8: idle cycles leave the register alone
   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> $stable(cond_fields));

   // R8: a request touches at most one field
   assert_one_field_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $countones(changed) <= 1);

   // R7: a trap leaves the register unchanged
   assert_trap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_type == TRAP_IEEE) |-> $stable(cond_fields));

   // R7: a trap always comes with a raised invalid flag
   assert_trap_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_type == TRAP_IEEE) |-> exc_flags[FLAG_INV]);

   // R5: only the invalid flag can ever be raised
   assert_flag_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
      exc_flags[3:0] == 4'b0000);

   // R4: a double NaN without trap writes unordered
   assert_nan_unordered_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req && is_double && dbl_nan_a && !trap_mask[FLAG_INV])
         |=> cond_fields[{sel_q, 1'b0} +: 2] == 2'd3);

   // R5/R6: ordered double operands never raise a flag
   assert_ordered_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req && is_double && !dbl_nan_a && !dbl_nan_b)
         |=> (exc_flags == 5'b0 && trap_type == TRAP_NONE));
endmodule

bind fcmp_cc_unit fcmp_cc_checker #(.NUM_FIELDS(NUM_FIELDS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req         (req),
   .op_a        (op_a),
   .op_b        (op_b),
   .is_double   (is_double),
   .trap_mask   (trap_mask),
   .field_sel   (field_sel),
   .cond_fields (cond_fields),
   .exc_flags   (exc_flags),
   .trap_type   (trap_type)
);

// File: tb/fcmp_cc_unit_tb.sv
module fcmp_cc_unit_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NF = 4;
   localparam int NK = 13;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic [63:0]   op_a = '0, op_b = '0;
   logic          is_double = 1'b0, signaling = 1'b0;
   logic [4:0]    trap_mask = '0;
   logic [1:0]    field_sel = '0;
   logic [2*NF-1:0] cond_fields;
   logic [4:0]    exc_flags;
   logic [1:0]    trap_type;

   int n_checks = 0;
   int n_fail   = 0;
   logic [1:0] model [NF];

   always #(CLK_PERIOD/2) clk = ~clk;

   fcmp_cc_unit #(.NUM_FIELDS(NF)) u_dut (
      .clk(clk), .rst_n(rst_n), .req(req), .op_a(op_a), .op_b(op_b),
      .is_double(is_double), .signaling(signaling), .trap_mask(trap_mask),
      .field_sel(field_sel), .cond_fields(cond_fields),
      .exc_flags(exc_flags), .trap_type(trap_type)
   );

   // kinds: 0 +0, 1 -0, 2 +sub, 3 -sub, 4 +1, 5 -1, 6 +1.5, 7 +2, 8 -2,
   //        9 +inf, 10 -inf, 11 qNaN, 12 sNaN
   function automatic logic [63:0] kind_bits(input int k, input logic dbl);
      logic [63:0] m;
      logic        neg;
      neg = (k == 1 || k == 3 || k == 5 || k == 8 || k == 10);
      if (dbl) begin
         case (k)
            0, 1:  m = 64'h0;
            2, 3:  m = 64'h1;
            4, 5:  m = 64'h3FF0_0000_0000_0000;
            6:     m = 64'h3FF8_0000_0000_0000;
            7, 8:  m = 64'h4000_0000_0000_0000;
            9, 10: m = 64'h7FF0_0000_0000_0000;
            11:    m = 64'h7FF8_0000_0000_0000;
            default: m = 64'h7FF0_0000_0000_0001;
         endcase
         return {neg, m[62:0]};
      end else begin
         case (k)
            0, 1:  m = 64'h0;
            2, 3:  m = 64'h1;
            4, 5:  m = 64'h3F80_0000;
            6:     m = 64'h3FC0_0000;
            7, 8:  m = 64'h4000_0000;
            9, 10: m = 64'h7F80_0000;
            11:    m = 64'h7FC0_0000;
            default: m = 64'h7F80_0001;
         endcase
         // R9: upper half filled with junk that must be ignored
         return {32'hDEAD_BEEF ^ 32'(k * 7919), neg, m[30:0]};
      end
   endfunction

   function automatic int kind_ord(input int k);
      case (k)
         0, 1: return 0;
         2: return 1;    3: return -1;
         4: return 10;   5: return -10;
         6: return 15;
         7: return 20;   8: return -20;
         9: return 100;  10: return -100;
         default: return 0;
      endcase
   endfunction

   task automatic check(input bit ok, input string req_tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req_tag, what, act, exp);
      end
   endtask

   function automatic logic [2*NF-1:0] model_vec();
      logic [2*NF-1:0] v;
      for (int i = 0; i < NF; i++) v[2*i +: 2] = model[i];
      return v;
   endfunction

   task automatic run_op(input int ka, input int kb, input logic dbl,
                         input logic sig, input logic [4:0] mask, input int sel);
      logic       nan_any, snan_any, inv, trap;
      logic [1:0] cc;
      int         oa, ob;
      op_a = kind_bits(ka, dbl);
      op_b = kind_bits(kb, dbl);
      is_double = dbl; signaling = sig; trap_mask = mask;
      field_sel = 2'(sel); req = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req = 1'b0;
      nan_any  = (ka >= 11) || (kb >= 11);
      snan_any = (ka == 12) || (kb == 12);
      oa = kind_ord(ka); ob = kind_ord(kb);
      if (nan_any)       cc = 2'd3;   // R4
      else if (oa == ob) cc = 2'd0;   // R2, R3
      else if (oa < ob)  cc = 2'd1;
      else               cc = 2'd2;
      inv  = sig ? nan_any : snan_any;  // R5, R6
      trap = inv && mask[4];            // R7
      if (!trap) model[sel] = cc;
      check(cond_fields == model_vec(), (trap ? "R7" : (nan_any ? "R4" : "R2")),
            "fields", 64'(cond_fields), 64'(model_vec()));
      check(exc_flags == {inv, 4'b0}, (sig ? "R6" : "R5"), "flags",
            64'(exc_flags), 64'({inv, 4'b0}));
      check(trap_type == {1'b0, trap}, "R7", "trap",
            64'(trap_type), 64'({1'b0, trap}));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      int sel;
      for (int i = 0; i < NF; i++) model[i] = 2'd0;
      repeat (3) @(negedge clk);
      // R1: outputs under reset
      check(cond_fields == '0 && exc_flags == '0 && trap_type == '0, "R1",
            "reset", {cond_fields, exc_flags, trap_type}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(cond_fields == '0 && exc_flags == '0 && trap_type == '0, "R1",
            "after reset", {cond_fields, exc_flags, trap_type}, 64'h0);

      sel = 0;
      for (int d = 0; d < 2; d++)
         for (int s = 0; s < 2; s++)
            for (int m = 0; m < 2; m++)
               for (int a = 0; a < NK; a++)
                  for (int b = 0; b < NK; b++) begin
                     run_op(a, b, d[0], s[0], (m == 0) ? 5'b01111 : 5'b10000, sel % NF);
                     sel++;
                  end

      // R8: an idle cycle with changing inputs leaves everything alone
      op_a = kind_bits(5, 1'b1); op_b = kind_bits(4, 1'b1);
      is_double = 1'b1; field_sel = 2'd0; req = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check(cond_fields == model_vec(), "R8", "idle hold",
            64'(cond_fields), 64'(model_vec()));

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule